// File: doc/BRIEF.md
# Dual-Counter Multi-Mode Timer

This block pairs two 16-bit down-counters that can be arranged, through a 2-bit mode field, as a self-running pulse-width generator with a spare timer, as a two-input timestamp unit, as two independent periodic timers, or as an edge-driven event counter next to a free-running timer. Software sets it up and reads it back through a small register bus. Two asynchronous event inputs feed the capture and event-count paths. One output carries the generated waveform. Four sticky level flags report underflows and captures and serve as interrupt requests.

Every counter steps down once per cycle in which `tick_en` is high. Counter 1 in mixed mode is the exception: it steps once per selected edge on event input A. When a counter is stopped it holds its preset value. In waveform mode, counter 1 loads the high time and the low time in turn, so the output runs with no help from software once it has been started. Each event input is synchronised by two flip-flops and then passed to an edge detector whose polarity software selects.

Top module: `twin_timer`

## Requirements
- R1: After reset every register reads 0 (control word, reload values, counters, capture registers, status), `pwm_out` is 0 and both flag outputs are 0.
- R2: The register map, word addressed, is: 0 control, 1 reload A, 2 reload B, 3 reload for counter 2, 4 counter 1, 5 counter 2, 6 capture A, 7 capture B, 8 status. In the control word, bits [1:0] are the mode (00 waveform, 01 dual capture, 10 dual timer, 11 event+timer), bit 2 runs counter 1, bit 3 runs counter 2, bit 4 selects the edge for input A and bit 5 the edge for input B (1 rising, 0 falling). A control write whose mode differs from the current mode stores the new mode with both run bits cleared.
- R3: A running counter decrements on each cycle with `tick_en` high. When it is at 0 it reloads instead, which gives a period of reload+1 ticks, and it sets its underflow flag (status bit 0 for counter 1, bit 1 for counter 2; `irq_uf` carries the same bits).
- R4: A stopped counter reads its preset: reload A for counter 1, the counter-2 reload for counter 2.
- R5: In waveform mode with counter 1 running, `pwm_out` is high for reload A + 1 ticks and then low for reload B + 1 ticks, and this repeats. It starts high in the cycle after the starting write. It toggles only on a counter-1 underflow. In any other mode, or when counter 1 is stopped, it is 0.
- R6: The status flags stay set until a status write with a 1 in their bit position. A write of 0 leaves them unchanged. A new event in the same cycle as the clearing write takes priority.
- R7: In dual-capture mode, a selected edge on input A copies counter 1 into capture A and sets status bit 2. A selected edge on input B copies counter 1 into capture B and sets status bit 3. Edges of the unselected polarity capture nothing. `irq_cap` carries bits 2 and 3.
- R8: In dual-timer mode both counters run from `tick_en`, and the event inputs change no capture register or flag.
- R9: In event+timer mode, counter 1 steps only on selected edges of input A and ignores `tick_en`. A selected edge on input B copies counter 2 into capture B and sets status bit 3.
- R10: Counter 2 is a periodic timer with its own reload in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Count enable for tick-driven counting |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register word address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` (combinational) |
| evt_a | input | 1 | Asynchronous event / capture input A |
| evt_b | input | 1 | Asynchronous event / capture input B |
| pwm_out | output | 1 | Generated waveform |
| irq_uf | output | 2 | Underflow flags, counter 1 in bit 0 |
| irq_cap | output | 2 | Capture flags, input A in bit 0 |

## Verification
The checker watches several rules on every clock. The waveform stays low outside running waveform mode and changes only on a counter-1 underflow. A mode-changing control write always leaves both run bits clear. Flags stay set until a 1 is written to them. An underflow always raises its flag. A stopped counter 2 follows its reload. No capture flag rises in dual-timer mode. Other properties need the directed scenarios to show them, because they depend on stimulus history: the exact high/low phase lengths, the reload+1 period, the capture-to-capture distance between two edges, edge polarity selection through the synchroniser, and event-driven stepping of counter 1.

// File: rtl/tct_pkg.sv
package tct_pkg;
  localparam int unsigned NUM_CH = 2;

  typedef enum logic [1:0] {
    MODE_PWM  = 2'b00,
    MODE_DCAP = 2'b01,
    MODE_DTMR = 2'b10,
    MODE_MIX  = 2'b11
  } tct_mode_e;

  localparam int unsigned REG_CTRL  = 0;
  localparam int unsigned REG_RLDA  = 1;
  localparam int unsigned REG_RLDB  = 2;
  localparam int unsigned REG_RLD2  = 3;
  localparam int unsigned REG_CNT1  = 4;
  localparam int unsigned REG_CNT2  = 5;
  localparam int unsigned REG_CAPA  = 6;
  localparam int unsigned REG_CAPB  = 7;
  localparam int unsigned REG_STAT  = 8;
endpackage

// File: rtl/tct_edge_sync.sv
module tct_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  input  logic rise_sel,
  output logic edge_o
);
  logic [STAGES:0] sh_q;
  logic [STAGES:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-1:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  // sh_q[STAGES-1] is the synchronised level, sh_q[STAGES] its previous value
  always_comb begin
    if (rise_sel) edge_o = sh_q[STAGES-1] & ~sh_q[STAGES];
    else          edge_o = ~sh_q[STAGES-1] & sh_q[STAGES];
  end
endmodule

// File: rtl/tct_down_counter.sv
module tct_down_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         dec,
  input  logic [W-1:0] preset_val,
  input  logic [W-1:0] reload_val,
  output logic [W-1:0] cnt_o,
  output logic         uf_o
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         at_zero;

  assign at_zero = (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    if (!run)         cnt_d = preset_val;
    else if (dec)     cnt_d = at_zero ? reload_val : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
  assign uf_o  = run & dec & at_zero;
endmodule

// File: rtl/twin_timer.sv
module twin_timer
  import tct_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wdata,
  output logic [CNT_W-1:0]  rdata,
  input  logic              evt_a,
  input  logic              evt_b,
  output logic              pwm_out,
  output logic [1:0]        irq_uf,
  output logic [1:0]        irq_cap
);
  localparam int unsigned CTRL_W = 6;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rs_q;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign srst_n = rs_q[1];

  // configuration state
  tct_mode_e              mode_q, mode_d;
  logic [NUM_CH-1:0]      run_q, run_d;
  logic [NUM_CH-1:0]      pol_q, pol_d;
  logic [CNT_W-1:0]       rlda_q, rldb_q, rld2_q;
  logic [NUM_CH-1:0][CNT_W-1:0] cap_q, cap_d;
  logic [NUM_CH-1:0]      uf_flag_q, uf_flag_d;
  logic [NUM_CH-1:0]      cap_flag_q, cap_flag_d;
  logic                   hi_q, hi_d;

  // write decode
  logic ctrl_we, rlda_we, rldb_we, rld2_we, stat_we;
  always_comb begin
    ctrl_we = wr_en && (addr == ADDR_W'(REG_CTRL));
    rlda_we = wr_en && (addr == ADDR_W'(REG_RLDA));
    rldb_we = wr_en && (addr == ADDR_W'(REG_RLDB));
    rld2_we = wr_en && (addr == ADDR_W'(REG_RLD2));
    stat_we = wr_en && (addr == ADDR_W'(REG_STAT));
  end

  // event inputs
  logic [NUM_CH-1:0] evt_in;
  logic [NUM_CH-1:0] edge_w;
  assign evt_in = {evt_b, evt_a};

  for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_sync
    tct_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (srst_n),
      .din      (evt_in[gi]),
      .rise_sel (pol_q[gi]),
      .edge_o   (edge_w[gi])
    );
  end

  // counters
  logic [NUM_CH-1:0]            dec_w, uf_w;
  logic [NUM_CH-1:0][CNT_W-1:0] cnt_w, preset_w, reload_w;
  logic                         pwm_mode, pwm_run;

  assign pwm_mode = (mode_q == MODE_PWM);
  assign pwm_run  = pwm_mode && run_q[0];

  always_comb begin
    dec_w[0]    = (mode_q == MODE_MIX) ? edge_w[0] : tick_en;
    dec_w[1]    = tick_en;
    preset_w[0] = rlda_q;
    reload_w[0] = (pwm_mode && hi_q) ? rldb_q : rlda_q;
    preset_w[1] = rld2_q;
    reload_w[1] = rld2_q;
  end

  for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_cnt
    tct_down_counter #(.W(CNT_W)) u_cnt (
      .clk        (clk),
      .rst_n      (srst_n),
      .run        (run_q[gi]),
      .dec        (dec_w[gi]),
      .preset_val (preset_w[gi]),
      .reload_val (reload_w[gi]),
      .cnt_o      (cnt_w[gi]),
      .uf_o       (uf_w[gi])
    );
  end

  // capture events
  logic [NUM_CH-1:0]            cap_ev;
  logic [NUM_CH-1:0][CNT_W-1:0] cap_src;
  always_comb begin
    cap_ev[0]  = edge_w[0] && (mode_q == MODE_DCAP);
    cap_ev[1]  = edge_w[1] && ((mode_q == MODE_DCAP) || (mode_q == MODE_MIX));
    cap_src[0] = cnt_w[0];
    cap_src[1] = (mode_q == MODE_MIX) ? cnt_w[1] : cnt_w[0];
  end

  // next state
  always_comb begin
    mode_d = mode_q;
    run_d  = run_q;
    pol_d  = pol_q;
    if (ctrl_we) begin
      mode_d = tct_mode_e'(wdata[1:0]);
      pol_d  = wdata[5:4];
      if (tct_mode_e'(wdata[1:0]) != mode_q) run_d = '0;
      else                                   run_d = wdata[3:2];
    end

    for (int i = 0; i < NUM_CH; i++) begin
      cap_d[i]      = cap_ev[i] ? cap_src[i] : cap_q[i];
      uf_flag_d[i]  = uf_w[i] | (uf_flag_q[i] & ~(stat_we & wdata[i]));
      cap_flag_d[i] = cap_ev[i] | (cap_flag_q[i] & ~(stat_we & wdata[2+i]));
    end

    if (!pwm_run)      hi_d = 1'b1;
    else if (uf_w[0])  hi_d = ~hi_q;
    else               hi_d = hi_q;
  end

  // registers
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      mode_q <= MODE_PWM;
      run_q  <= '0;
      pol_q  <= '0;
    end else if (ctrl_we) begin
      mode_q <= mode_d;
      run_q  <= run_d;
      pol_q  <= pol_d;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)      rlda_q <= '0;
    else if (rlda_we) rlda_q <= wdata;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)      rldb_q <= '0;
    else if (rldb_we) rldb_q <= wdata;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)      rld2_q <= '0;
    else if (rld2_we) rld2_q <= wdata;
  end

  for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_cap
    always_ff @(posedge clk or negedge srst_n) begin
      if (!srst_n)         cap_q[gi] <= '0;
      else if (cap_ev[gi]) cap_q[gi] <= cap_d[gi];
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      uf_flag_q  <= '0;
      cap_flag_q <= '0;
      hi_q       <= 1'b1;
    end else begin
      uf_flag_q  <= uf_flag_d;
      cap_flag_q <= cap_flag_d;
      hi_q       <= hi_d;
    end
  end

  // read mux
  always_comb begin
    rdata = '0;
    case (addr)
      ADDR_W'(REG_CTRL): rdata = CNT_W'({pol_q, run_q, mode_q});
      ADDR_W'(REG_RLDA): rdata = rlda_q;
      ADDR_W'(REG_RLDB): rdata = rldb_q;
      ADDR_W'(REG_RLD2): rdata = rld2_q;
      ADDR_W'(REG_CNT1): rdata = cnt_w[0];
      ADDR_W'(REG_CNT2): rdata = cnt_w[1];
      ADDR_W'(REG_CAPA): rdata = cap_q[0];
      ADDR_W'(REG_CAPB): rdata = cap_q[1];
      ADDR_W'(REG_STAT): rdata = CNT_W'({cap_flag_q, uf_flag_q});
      default:           rdata = '0;
    endcase
  end

  assign pwm_out = pwm_run && hi_q;
  assign irq_uf  = uf_flag_q;
  assign irq_cap = cap_flag_q;

  logic unused_ok;
  assign unused_ok = ^{CTRL_W[0]};
endmodule

// File: rtl/tct_checker.sv
module tct_checker #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [CNT_W-1:0]  wdata,
  input logic [1:0]        mode,
  input logic [1:0]        run,
  input logic [1:0]        uf,
  input logic              pwm_out,
  input logic [1:0]        irq_uf,
  input logic [1:0]        irq_cap,
  input logic [CNT_W-1:0]  cnt2,
  input logic [CNT_W-1:0]  rld2
);
  logic ctrl_wr, stat_wr;
  assign ctrl_wr = wr_en && (addr == ADDR_W'(0));
  assign stat_wr = wr_en && (addr == ADDR_W'(8));

  AST_PWM_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'b00 || !run[0]) |-> !pwm_out); // R5

  AST_PWM_TOGGLE_ONLY_UF: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00 && run[0] && !uf[0]) |=> (!(mode == 2'b00 && run[0]) || $stable(pwm_out))); // R5

  AST_MODE_CHANGE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && wdata[1:0] != mode) |=> (run == 2'b00)); // R2

  AST_UF1_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_uf[0] && !(stat_wr && wdata[0])) |=> irq_uf[0]); // R6

  AST_UF2_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_uf[1] && !(stat_wr && wdata[1])) |=> irq_uf[1]); // R6

  AST_UF_RAISES_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    uf[0] |=> irq_uf[0]); // R3

  AST_STOPPED_PRESET: assert property (@(posedge clk) disable iff (!rst_n)
    !run[1] |=> (cnt2 == $past(rld2))); // R4

  AST_NO_CAP_DTMR: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10 && irq_cap == 2'b00) |=> (irq_cap == 2'b00)); // R8
endmodule

bind twin_timer tct_checker #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rst_n   (srst_n),
  .wr_en   (wr_en),
  .addr    (addr),
  .wdata   (wdata),
  .mode    (mode_q),
  .run     (run_q),
  .uf      (uf_w),
  .pwm_out (pwm_out),
  .irq_uf  (irq_uf),
  .irq_cap (irq_cap),
  .cnt2    (cnt_w[1]),
  .rld2    (rld2_q)
);

// File: tb/tb_twin_timer.sv
module tb_twin_timer;
  logic        clk;
  logic        rst_n;
  logic        tick_en;
  logic        wr_en;
  logic [3:0]  addr;
  logic [15:0] wdata;
  logic [15:0] rdata;
  logic        evt_a, evt_b;
  logic        pwm_out;
  logic [1:0]  irq_uf, irq_cap;

  int n_chk;
  int n_bad;
  bit done;

  twin_timer dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .evt_a(evt_a), .evt_b(evt_b),
    .pwm_out(pwm_out), .irq_uf(irq_uf), .irq_cap(irq_cap)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    for (int a = 0; a < 9; a++) begin
      rd(4'(a), v);
      check("R1 register", v, 16'h0);
    end
    check("R1 pwm_out", {15'b0, pwm_out}, 16'h0);
    check("R1 flags", {12'b0, irq_cap, irq_uf}, 16'h0);
  endtask

  task automatic t_dual_timer();
    logic [15:0] v1, v2, v3;
    wr(4'd1, 16'd4);
    wr(4'd3, 16'd2);
    rd(4'd4, v1);
    check("R4 stopped counter 1 preset", v1, 16'd4);
    wr(4'd0, 16'h000E);
    rd(4'd0, v1);
    check("R2 mode change clears run bits", v1, 16'h0002);
    wr(4'd0, 16'h000E);
    rd(4'd4, v1); rd(4'd5, v2);
    check("R3 counter 1 start value", v1, 16'd4);
    check("R10 counter 2 start value", v2, 16'd2);
    wait_n(3);
    rd(4'd4, v1); rd(4'd5, v2); rd(4'd8, v3);
    check("R3 counter 1 after 3 ticks", v1, 16'd1);
    check("R10 counter 2 reloaded after period", v2, 16'd2);
    check("R10 counter 2 underflow flag", v3, 16'h0002);
    wait_n(2);
    rd(4'd4, v1); rd(4'd8, v3);
    check("R3 counter 1 reload after period 5", v1, 16'd4);
    check("R3 both underflow flags", v3, 16'h0003);
    wr(4'd8, 16'h0001);
    rd(4'd8, v3);
    check("R6 write-1 clears bit 0 only", v3, 16'h0002);
    wr(4'd0, 16'h0002);
    wr(4'd8, 16'h0000);
    rd(4'd8, v3);
    check("R6 write-0 leaves flag", v3, 16'h0002);
    wr(4'd8, 16'h000F);
    evt_a = 1'b1; evt_b = 1'b0; wait_n(6);
    evt_a = 1'b0; evt_b = 1'b1; wait_n(6);
    rd(4'd8, v3);
    check("R8 inputs ignored in dual-timer mode", v3, 16'h0000);
  endtask

  task automatic t_pwm();
    int bad = 0;
    wr(4'd1, 16'd3);
    wr(4'd2, 16'd5);
    wr(4'd0, 16'h0004);
    check("R5 low while stopped", {15'b0, pwm_out}, 16'h0);
    wr(4'd0, 16'h0004);
    for (int n = 0; n < 30; n++) begin
      #1;
      if (pwm_out !== ((n % 10) < 4)) bad++;
      @(negedge clk);
    end
    check("R5 high/low phase pattern mismatches", 16'(bad), 16'd0);
    wr(4'd0, 16'h0000);
    #1;
    check("R5 low after stop", {15'b0, pwm_out}, 16'h0);
  endtask

  task automatic t_capture();
    logic [15:0] ca, cb, st;
    wr(4'd1, 16'd1000);
    wr(4'd0, 16'h0015);
    wr(4'd0, 16'h0015);
    wr(4'd8, 16'h000F);
    @(negedge clk); evt_a = 1'b1;
    wait_n(10);     evt_b = 1'b0;
    wait_n(8);
    rd(4'd6, ca); rd(4'd7, cb); rd(4'd8, st);
    check("R7 capture distance A-B", ca - cb, 16'd10);
    check("R7 both capture flags", st & 16'h000C, 16'h000C);
    check("R7 irq_cap output", {14'b0, irq_cap}, 16'h0003);
    wr(4'd8, 16'h000C);
    @(negedge clk); evt_a = 1'b0; evt_b = 1'b1;
    wait_n(8);
    rd(4'd8, st);
    check("R7 unselected polarity ignored", st & 16'h000C, 16'h0000);
  endtask

  task automatic t_mixed();
    logic [15:0] v, st;
    wr(4'd1, 16'd5);
    wr(4'd3, 16'd77);
    wr(4'd0, 16'h0027);
    wr(4'd0, 16'h0027);
    wr(4'd8, 16'h000F);
    for (int k = 0; k < 3; k++) begin
      evt_a = 1'b1; wait_n(6);
      evt_a = 1'b0; wait_n(6);
    end
    rd(4'd4, v);
    check("R9 counter 1 steps on falling edges only", v, 16'd2);
    for (int k = 0; k < 3; k++) begin
      evt_a = 1'b1; wait_n(6);
      evt_a = 1'b0; wait_n(6);
    end
    rd(4'd4, v); rd(4'd8, st);
    check("R9 event counter reload", v, 16'd5);
    check("R9 event counter underflow flag", st & 16'h0001, 16'h0001);
    evt_b = 1'b0; wait_n(6);
    evt_b = 1'b1; wait_n(6);
    rd(4'd7, v); rd(4'd8, st);
    check("R9 input B captures counter 2", v, 16'd77);
    check("R9 capture B flag", st & 16'h000C, 16'h0008);
  endtask

  initial begin
    done = 1'b0;
    n_chk = 0; n_bad = 0;
    rst_n = 1'b0; tick_en = 1'b1; wr_en = 1'b0; addr = '0; wdata = '0;
    evt_a = 1'b0; evt_b = 1'b1;
    wait_n(5);
    rst_n = 1'b1;
    wait_n(4);
    t_reset();
    t_dual_timer();
    t_pwm();
    t_capture();
    t_mixed();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule